// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Sequencer

This controller writes a complete byte-wide one-time-programmable memory from a source data stream. It first asks for the core rail to be raised and then for the programming rail, waiting for each acknowledge and a settle time. It then walks the address space three times. The first walk applies one unverified strobe pulse to each byte. The second walk reads each byte back and adds single pulses, each followed by a read, until the byte matches or a pulse budget runs out. After both rails return to nominal, the third walk reads every byte and compares it with the source again.

Data comes from a request/valid port that is indexed by address, so each walk fetches its bytes again. The memory is driven through active-low chip-enable, output-enable and program-strobe lines, with a separate drive enable for the write-data bus. A byte that runs out of pulses, or a mismatch in the last walk, stops the sequence at once and latches that address. Rails that are still raised are then lowered in the safe order. The block reports the result with `done`, `pass` and `fail`.

Top module: `otp_seq_top`

## Requirements
- R1: After reset, chip enable, output enable and program strobe are high (inactive), neither rail request is asserted, and `busy` and `done` are low.
- R2: The programming rail is requested only while the core rail is requested and acknowledged, and at least SUPPLY_CYC cycles after that acknowledge. When lowering, the core request drops at least SUPPLY_CYC cycles after the programming acknowledge has fallen.
- R3: The strobe is low only while chip enable is low, output enable is high, write data is driven and the programming rail is acknowledged. Every pulse lasts exactly PULSE_CYC cycles.
- R4: Write data and address are driven for exactly SETUP_CYC cycles before each pulse and for HOLD_CYC cycles after it, and they stay stable during the pulse.
- R5: In the first walk every address gets exactly one pulse, and output enable is never taken low.
- R6: In the second walk a mismatching byte gets one more pulse and one more read per failed read, up to MAX_PULSES pulses. A byte that matches within that budget lets the walk continue.
- R7: A byte that still mismatches after MAX_PULSES second-walk pulses ends the sequence. Its address is latched, both rails are lowered, and the block finishes with `fail` high and `pass` low.
- R8: The last walk runs with both rails released and unacknowledged, and reads every byte. The first mismatch finishes the sequence with `fail` and latches that address.
- R9: The write-data drive enable is never high while output enable is low.
- R10: `srcReq` stays high with a stable `srcAddr` until `srcValid`. Each walk fetches every address it visits exactly once.
- R11: A fully matching run ends with `done` and `pass` high, `fail` low, and both rail requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a sequence when idle or finished |
| srcReq | output | 1 | Source data request |
| srcAddr | output | ADDR_W | Address of the requested byte |
| srcData | input | DATA_W | Source byte |
| srcValid | input | 1 | Source byte valid |
| memAddr | output | ADDR_W | Memory address lines |
| memDout | output | DATA_W | Write data to the memory |
| memDrive | output | 1 | Drive enable for write data |
| memDin | input | DATA_W | Read data from the memory |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memPgmN | output | 1 | Program strobe, active low |
| vccHiReq | output | 1 | Request raised core rail |
| vccHiAck | input | 1 | Core rail raised |
| vppHiReq | output | 1 | Request raised programming rail |
| vppHiAck | input | 1 | Programming rail raised |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (held) |
| pass | output | 1 | Finished without a mismatch |
| fail | output | 1 | A mismatch aborted the sequence |
| failAddr | output | ADDR_W | Address that caused the abort |

## Verification
The per-cycle properties cover the strobe's qualifying conditions, the rail ordering and the absence of read verifies during the first walk. They also cover the nominal rails during the last walk, bus contention, source handshake stability, a bounded retry counter and a held failing address. Only the directed scenarios can show exact pulse, setup and hold lengths, settle distances, and total pulse and fetch counts. The same holds for which address fails when a byte needs exactly the full retry budget, one pulse more, or reads back wrong only at nominal rails.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [2:0] {
    TM_SETUP,
    TM_PULSE,
    TM_HOLD,
    TM_READ,
    TM_SUPPLY
  } tmrSel_e;

  typedef enum logic [1:0] {
    PH_BURN,
    PH_VERIFY,
    PH_FINAL
  } phase_e;

  typedef struct packed {
    logic    addrClr;
    logic    addrInc;
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    retryClr;
    logic    retryInc;
    logic    dataLoad;
    logic    failLatch;
    logic    failClr;
  } ctlStrobe_t;

endpackage

// File: rtl/otp_seq_dp.sv
module otp_seq_dp
  import otp_seq_pkg::*;
#(
  parameter int DEPTH      = 131072,
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 25000,
  parameter int SETUP_CYC  = 500,
  parameter int HOLD_CYC   = 500,
  parameter int READ_CYC   = 38,
  parameter int SUPPLY_CYC = 500,
  parameter int MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataReg,
  output logic              addrLast,
  output logic              tmrDone,
  output logic              retryMax,
  output logic              match,
  output logic              failFlag,
  output logic [ADDR_W-1:0] failAddr
);

  localparam int TMAX_A  = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int TMAX_B  = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int TMAX_C  = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMR_MAX = (TMAX_C > SUPPLY_CYC) ? TMAX_C : SUPPLY_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int RTY_W   = $clog2(MAX_PULSES + 1);

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] tmrLoadVal;
  logic [RTY_W-1:0] retryCnt;

  // Address walker
  always_ff @(posedge clk) begin
    if (!rstN)            addr <= '0;
    else if (stb.addrClr) addr <= '0;
    else if (stb.addrInc) addr <= addr + 1'b1;
  end
  assign addrLast = (addr == ADDR_W'(DEPTH - 1));

  // Interval timer, loaded with length-1 so a state lasts exactly length cycles
  always_comb begin
    unique case (stb.tmrSel)
      TM_PULSE:  tmrLoadVal = TMR_W'(PULSE_CYC - 1);
      TM_HOLD:   tmrLoadVal = TMR_W'(HOLD_CYC - 1);
      TM_READ:   tmrLoadVal = TMR_W'(READ_CYC - 1);
      TM_SUPPLY: tmrLoadVal = TMR_W'(SUPPLY_CYC - 1);
      default:   tmrLoadVal = TMR_W'(SETUP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            tmr <= '0;
    else if (stb.tmrLoad) tmr <= tmrLoadVal;
    else if (tmr != '0)   tmr <= tmr - 1'b1;
  end
  assign tmrDone = (tmr == '0);

  // Second-walk pulse counter
  always_ff @(posedge clk) begin
    if (!rstN)             retryCnt <= '0;
    else if (stb.retryClr) retryCnt <= '0;
    else if (stb.retryInc) retryCnt <= retryCnt + 1'b1;
  end
  assign retryMax = (retryCnt == RTY_W'(MAX_PULSES));

  // R6
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.retryInc |-> !retryMax);

  // Intended byte and read-back comparison
  always_ff @(posedge clk) begin
    if (!rstN)             dataReg <= '0;
    else if (stb.dataLoad) dataReg <= srcData;
  end
  assign match = (memDin == dataReg);

  // Failure latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failFlag <= 1'b0;
      failAddr <= '0;
    end else if (stb.failClr) begin
      failFlag <= 1'b0;
    end else if (stb.failLatch) begin
      failFlag <= 1'b1;
      failAddr <= addr;
    end
  end

  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !stb.failClr && !stb.failLatch) |=> (failFlag && $stable(failAddr)));

  // R10
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrInc |-> !addrLast);

endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
  import otp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       srcValid,
  input  logic       vccAck,
  input  logic       vppAck,
  input  logic       addrLast,
  input  logic       tmrDone,
  input  logic       retryMax,
  input  logic       match,
  input  logic       failFlag,
  output ctlStrobe_t stb,
  output logic       srcReq,
  output logic       memCeN,
  output logic       memOeN,
  output logic       memPgmN,
  output logic       memDrive,
  output logic       vccReq,
  output logic       vppReq,
  output logic       busy,
  output logic       done
);

  typedef enum logic [4:0] {
    S_IDLE, S_VCC_UP, S_VCC_SET, S_VPP_UP, S_VPP_SET,
    S_FETCH, S_PG_SETUP, S_PG_PULSE, S_PG_HOLD,
    S_VF_READ, S_VF_CHECK, S_NEXT,
    S_VPP_DN, S_VPP_CLR, S_VCC_DN, S_VCC_CLR, S_FINISH
  } state_e;

  state_e st, stNext;
  phase_e ph, phNext;
  logic   vccNext, vppNext;

  always_comb begin
    stb     = '0;
    stNext  = st;
    phNext  = ph;
    vccNext = vccReq;
    vppNext = vppReq;
    unique case (st)
      S_IDLE, S_FINISH: begin
        if (start) begin
          stb.failClr = 1'b1;
          stb.addrClr = 1'b1;
          phNext      = PH_BURN;
          vccNext     = 1'b1;
          stNext      = S_VCC_UP;
        end
      end
      S_VCC_UP: begin
        if (vccAck) begin
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_SUPPLY;
          stNext      = S_VCC_SET;
        end
      end
      S_VCC_SET: begin
        if (tmrDone) begin
          vppNext = 1'b1;
          stNext  = S_VPP_UP;
        end
      end
      S_VPP_UP: begin
        if (vppAck) begin
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_SUPPLY;
          stNext      = S_VPP_SET;
        end
      end
      S_VPP_SET: begin
        if (tmrDone) stNext = S_FETCH;
      end
      S_FETCH: begin
        if (srcValid) begin
          stb.dataLoad = 1'b1;
          stb.retryClr = 1'b1;
          stb.tmrLoad  = 1'b1;
          if (ph == PH_BURN) begin
            stb.tmrSel = TM_SETUP;
            stNext     = S_PG_SETUP;
          end else begin
            stb.tmrSel = TM_READ;
            stNext     = S_VF_READ;
          end
        end
      end
      S_PG_SETUP: begin
        if (tmrDone) begin
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_PULSE;
          stNext      = S_PG_PULSE;
        end
      end
      S_PG_PULSE: begin
        if (tmrDone) begin
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_HOLD;
          stNext      = S_PG_HOLD;
        end
      end
      S_PG_HOLD: begin
        if (tmrDone) begin
          if (ph == PH_BURN) begin
            stNext = S_NEXT;
          end else begin
            stb.tmrLoad = 1'b1;
            stb.tmrSel  = TM_READ;
            stNext      = S_VF_READ;
          end
        end
      end
      S_VF_READ: begin
        if (tmrDone) stNext = S_VF_CHECK;
      end
      S_VF_CHECK: begin
        if (match) begin
          stNext = S_NEXT;
        end else if (ph == PH_FINAL) begin
          stb.failLatch = 1'b1;
          stNext        = S_FINISH;
        end else if (retryMax) begin
          stb.failLatch = 1'b1;
          vppNext       = 1'b0;
          stNext        = S_VPP_DN;
        end else begin
          stb.retryInc = 1'b1;
          stb.tmrLoad  = 1'b1;
          stb.tmrSel   = TM_SETUP;
          stNext       = S_PG_SETUP;
        end
      end
      S_NEXT: begin
        if (addrLast) begin
          stb.addrClr = 1'b1;
          unique case (ph)
            PH_BURN: begin
              phNext = PH_VERIFY;
              stNext = S_FETCH;
            end
            PH_VERIFY: begin
              vppNext = 1'b0;
              stNext  = S_VPP_DN;
            end
            default: stNext = S_FINISH;
          endcase
        end else begin
          stb.addrInc = 1'b1;
          stNext      = S_FETCH;
        end
      end
      S_VPP_DN: begin
        if (!vppAck) begin
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_SUPPLY;
          stNext      = S_VPP_CLR;
        end
      end
      S_VPP_CLR: begin
        if (tmrDone) begin
          vccNext = 1'b0;
          stNext  = S_VCC_DN;
        end
      end
      S_VCC_DN: begin
        if (!vccAck) begin
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TM_SUPPLY;
          stNext      = S_VCC_CLR;
        end
      end
      S_VCC_CLR: begin
        if (tmrDone) begin
          if (failFlag) begin
            stNext = S_FINISH;
          end else begin
            phNext = PH_FINAL;
            stNext = S_FETCH;
          end
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= S_IDLE;
      ph     <= PH_BURN;
      vccReq <= 1'b0;
      vppReq <= 1'b0;
    end else begin
      st     <= stNext;
      ph     <= phNext;
      vccReq <= vccNext;
      vppReq <= vppNext;
    end
  end

  assign busy     = (st != S_IDLE) && (st != S_FINISH);
  assign done     = (st == S_FINISH);
  assign srcReq   = (st == S_FETCH);
  assign memDrive = (st == S_PG_SETUP) || (st == S_PG_PULSE) || (st == S_PG_HOLD);
  assign memPgmN  = (st != S_PG_PULSE);
  assign memOeN   = !((st == S_VF_READ) || (st == S_VF_CHECK));
  assign memCeN   = !((st == S_FETCH) || (st == S_PG_SETUP) || (st == S_PG_PULSE) ||
                      (st == S_PG_HOLD) || (st == S_VF_READ) || (st == S_VF_CHECK) ||
                      (st == S_NEXT));

  // R3
  pgm_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memPgmN |-> (!memCeN && memOeN && memDrive && vppAck));

  // R2
  supply_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    vppReq |-> (vccReq && vccAck));

  // R9
  bus_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDrive |-> memOeN);

  // R5
  burn_no_verify_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ph == PH_BURN) |-> memOeN);

  // R8
  final_nominal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_FINAL && !memOeN) |-> (!vccAck && !vppAck && !vccReq && !vppReq));

  // R10
  src_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq && !srcValid) |=> srcReq);

endmodule

// File: rtl/otp_seq_top.sv
module otp_seq_top
  import otp_seq_pkg::*;
#(
  parameter int DEPTH      = 131072,
  parameter int ADDR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 25000,
  parameter int SETUP_CYC  = 500,
  parameter int HOLD_CYC   = 500,
  parameter int READ_CYC   = 38,
  parameter int SUPPLY_CYC = 500,
  parameter int MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              srcReq,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive,
  input  logic [DATA_W-1:0] memDin,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memPgmN,
  output logic              vccHiReq,
  input  logic              vccHiAck,
  output logic              vppHiReq,
  input  logic              vppHiAck,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  ctlStrobe_t        stb;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataReg;
  logic              addrLast, tmrDone, retryMax, match, failFlag;

  otp_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .srcValid (srcValid),
    .vccAck   (vccHiAck),
    .vppAck   (vppHiAck),
    .addrLast (addrLast),
    .tmrDone  (tmrDone),
    .retryMax (retryMax),
    .match    (match),
    .failFlag (failFlag),
    .stb      (stb),
    .srcReq   (srcReq),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memPgmN  (memPgmN),
    .memDrive (memDrive),
    .vccReq   (vccHiReq),
    .vppReq   (vppHiReq),
    .busy     (busy),
    .done     (done)
  );

  otp_seq_dp #(
    .DEPTH      (DEPTH),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .READ_CYC   (READ_CYC),
    .SUPPLY_CYC (SUPPLY_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcData  (srcData),
    .memDin   (memDin),
    .addr     (addr),
    .dataReg  (dataReg),
    .addrLast (addrLast),
    .tmrDone  (tmrDone),
    .retryMax (retryMax),
    .match    (match),
    .failFlag (failFlag),
    .failAddr (failAddr)
  );

  assign srcAddr = addr;
  assign memAddr = addr;
  assign memDout = dataReg;
  assign fail    = failFlag;
  assign pass    = done && !failFlag;

  // R4
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memPgmN && $past(!memPgmN)) |-> ($stable(memAddr) && $stable(memDout)));

  // R10
  src_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq && !srcValid) |=> $stable(srcAddr));

endmodule

// File: tb/otp_seq_top_tb.sv
module otp_seq_top_tb;

  localparam int DEPTH  = 6;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int PULSE  = 12;
  localparam int SETUP  = 3;
  localparam int HOLD   = 2;
  localparam int READ   = 2;
  localparam int SUPPLY = 5;
  localparam int MAXP   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic srcReq, srcValid;
  logic [ADDR_W-1:0] srcAddr, memAddr, failAddr;
  logic [DATA_W-1:0] srcData, memDout, memDin;
  logic memDrive, memCeN, memOeN, memPgmN;
  logic vccHiReq, vppHiReq, vccHiAck, vppHiAck;
  logic busy, done, pass, fail;

  always #2 clk = ~clk;

  otp_seq_top #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE),
    .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .READ_CYC(READ), .SUPPLY_CYC(SUPPLY),
    .MAX_PULSES(MAXP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcReq(srcReq), .srcAddr(srcAddr), .srcData(srcData), .srcValid(srcValid),
    .memAddr(memAddr), .memDout(memDout), .memDrive(memDrive), .memDin(memDin),
    .memCeN(memCeN), .memOeN(memOeN), .memPgmN(memPgmN),
    .vccHiReq(vccHiReq), .vccHiAck(vccHiAck), .vppHiReq(vppHiReq), .vppHiAck(vppHiAck),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .failAddr(failAddr)
  );

  int checks = 0;
  int failures = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 8'h7F);
  endfunction

  // Memory model: a byte takes its data after need[] pulses with the programming rail up
  logic [7:0] memArr [DEPTH];
  int pulseCnt [DEPTH];
  int need [DEPTH];
  int finalBad = -1;
  logic prevPgm = 1'b1;

  always @(posedge clk) begin
    prevPgm <= memPgmN;
    if (!prevPgm && memPgmN && vppHiAck) begin
      pulseCnt[memAddr] = pulseCnt[memAddr] + 1;
      if (pulseCnt[memAddr] >= need[memAddr])
        memArr[memAddr] = memArr[memAddr] & memDout;
    end
  end

  assign memDin = (!memCeN && !memOeN)
    ? (memArr[memAddr] ^ ((int'(memAddr) == finalBad && !vppHiAck) ? 8'h01 : 8'h00))
    : 8'h00;

  // Rail acknowledges follow requests after three cycles
  logic [2:0] vccSh = '0, vppSh = '0;
  always @(posedge clk) begin
    vccSh <= {vccSh[1:0], vccHiReq};
    vppSh <= {vppSh[1:0], vppHiReq};
  end
  assign vccHiAck = vccSh[2];
  assign vppHiAck = vppSh[2];

  // Source with one cycle of latency
  always @(posedge clk) begin
    srcValid <= srcReq && !srcValid;
    srcData  <= pat(int'(srcAddr));
  end

  // Monitors, sampled away from the active edge
  int lowRun, setRun, holdRun, pulseTotal, widthErr, setupErr, holdErr;
  int orderErr, fetchTotal, vccAckRun, vppLowRun;
  bit afterPulse;
  logic prevVppReq, prevVccReq;

  always @(negedge clk) begin
    if (!rstN) begin
      lowRun = 0; setRun = 0; holdRun = 0; pulseTotal = 0; widthErr = 0;
      setupErr = 0; holdErr = 0; orderErr = 0; fetchTotal = 0;
      vccAckRun = 0; vppLowRun = 0; afterPulse = 0;
      prevVppReq = 0; prevVccReq = 0;
    end else begin
      if (!memPgmN) begin
        if (lowRun == 0) begin
          if (setRun != SETUP) setupErr++;
          setRun = 0;
          afterPulse = 1;
        end
        lowRun++;
      end else begin
        if (lowRun != 0) begin
          pulseTotal++;
          if (lowRun != PULSE) widthErr++;
          lowRun = 0;
        end
        if (memDrive && !afterPulse) setRun++;
        if (memDrive && afterPulse) holdRun++;
        if (!memDrive && afterPulse) begin
          if (holdRun != HOLD) holdErr++;
          holdRun = 0;
          afterPulse = 0;
        end
      end
      if (srcValid) fetchTotal++;
      if (vppHiReq && !prevVppReq && vccAckRun < SUPPLY) orderErr++;
      if (!vccHiReq && prevVccReq && vppLowRun < SUPPLY) orderErr++;
      vccAckRun  = vccHiAck ? vccAckRun + 1 : 0;
      vppLowRun  = (!vppHiAck && vccHiReq) ? vppLowRun + 1 : 0;
      prevVppReq = vppHiReq;
      prevVccReq = vccHiReq;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    start = 1'b0;
    finalBad = -1;
    for (int i = 0; i < DEPTH; i++) begin
      memArr[i] = 8'hFF;
      pulseCnt[i] = 0;
      need[i] = 1;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_seq(output bit finished);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finished = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin
        finished = 1;
        break;
      end
    end
    check(finished, "R7", "watchdog done reached", int'(finished), 1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(memCeN && memOeN && memPgmN, "R1", "pins idle high",
          int'({memCeN, memOeN, memPgmN}), 7);
    check(!vccHiReq && !vppHiReq, "R1", "rail requests low",
          int'({vccHiReq, vppHiReq}), 0);
    check(!busy && !done, "R1", "busy/done low", int'({busy, done}), 0);
  endtask

  task automatic t_clean();
    bit fin;
    do_reset();
    run_seq(fin);
    check(pass && !fail, "R11", "clean pass", int'({pass, fail}), 2);
    check(pulseTotal == DEPTH, "R5", "one pulse per byte", pulseTotal, DEPTH);
    check(widthErr == 0, "R3", "pulse width errors", widthErr, 0);
    check(setupErr == 0 && holdErr == 0, "R4", "setup/hold errors",
          setupErr + holdErr, 0);
    check(orderErr == 0, "R2", "rail order/settle errors", orderErr, 0);
    check(!vccHiReq && !vppHiReq, "R11", "rails released", int'({vccHiReq, vppHiReq}), 0);
    check(fetchTotal == 3 * DEPTH, "R10", "fetch count", fetchTotal, 3 * DEPTH);
  endtask

  task automatic t_retry_mid();
    bit fin;
    do_reset();
    need[2] = 4;
    run_seq(fin);
    check(pass, "R6", "stubborn byte recovers", int'(pass), 1);
    check(pulseTotal == DEPTH + 3, "R6", "extra pulses", pulseTotal, DEPTH + 3);
    check(widthErr == 0 && setupErr == 0 && holdErr == 0, "R4", "retry timing",
          widthErr + setupErr + holdErr, 0);
  endtask

  task automatic t_retry_edge();
    bit fin;
    do_reset();
    need[5] = MAXP + 1;
    run_seq(fin);
    check(pass, "R6", "byte matching on last allowed pulse", int'(pass), 1);
    check(pulseTotal == DEPTH + MAXP, "R6", "full budget pulses", pulseTotal, DEPTH + MAXP);
  endtask

  task automatic t_retry_exhaust();
    bit fin;
    do_reset();
    need[3] = MAXP + 2;
    run_seq(fin);
    check(fail && !pass, "R7", "exhausted byte fails", int'({pass, fail}), 1);
    check(int'(failAddr) == 3, "R7", "failing address", int'(failAddr), 3);
    check(pulseTotal == DEPTH + MAXP, "R7", "pulses before abort", pulseTotal, DEPTH + MAXP);
    check(fetchTotal == DEPTH + 4, "R7", "no fetch after abort", fetchTotal, DEPTH + 4);
    check(!vccHiReq && !vppHiReq && orderErr == 0, "R2", "rails lowered in order",
          int'({vccHiReq, vppHiReq}) + orderErr, 0);
  endtask

  task automatic t_final_mismatch();
    bit fin;
    do_reset();
    finalBad = 4;
    run_seq(fin);
    check(fail && !pass, "R8", "nominal-rail mismatch fails", int'({pass, fail}), 1);
    check(int'(failAddr) == 4, "R8", "final failing address", int'(failAddr), 4);
    check(fetchTotal == 2 * DEPTH + 5, "R8", "final walk stops at mismatch",
          fetchTotal, 2 * DEPTH + 5);
    check(memOeN && !memDrive, "R9", "bus quiet at end", int'({memOeN, memDrive}), 2);
  endtask

  initial begin
    t_reset_state();
    t_clean();
    t_retry_mid();
    t_retry_edge();
    t_retry_exhaust();
    t_final_mismatch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule